// File: doc/BRIEF.md
# Sequential Oblique Decision-Tree Classifier

This block classifies one instance at a time with a binary oblique decision tree. One shared node evaluator handles every node at every level, and it has one multiplier and one adder. The tree's tables are fixed when the block is built. Each node holds a coefficient for every attribute plus a stored threshold. The evaluator forms the weighted attribute sum over N_ATTR cycles and compares it with the threshold on the next cycle. That outcome picks one of the node's two child entries. A child address of zero means a leaf, and the class stored beside it becomes the result. Any other address names the next node to evaluate.

The block alternates between a load mode and a classify mode. In load mode, software-independent logic upstream writes attributes through an index/data/strobe port and then pulses start. Classification always begins at node 0. It visits only the nodes on the path to the leaf. It ends with a one-cycle done pulse that carries the class, and the block then returns to load mode. The default tables hold a two-node tree that solves two-input XOR: equal binary inputs give class 1, unequal inputs give class 2.

Top module: `dt_seq_classifier`

## Requirements
- R1: While rst is high and in the first cycle after it, done is 0, result_class is 0, and the block is in load mode, ready to accept start.
- R2: In load mode, a cycle with attr_we high stores attr_data (signed) into attribute slot attr_idx, and a later classification uses that value.
- R3: start sampled high in load mode enters classify mode with the accumulator cleared, at node 0 and attribute step 0.
- R4: A node takes the upper child field when the sum over all attributes of coefficient times attribute is greater than or equal to the node's stored threshold, and takes the lower field otherwise. Coefficients and thresholds carry two fractional bits and attributes are integers. The default tree sums both attributes with weight 1.0 at both nodes. Node 0 has threshold 0.5, upper child node 1, and lower leaf class 1. Node 1 has threshold 1.5, upper leaf class 1, and lower leaf class 2.
- R5: A selected child address of zero ends classification with the class field of that same child. The class field of a non-leaf child has no effect.
- R6: done rises exactly V*(N_ATTR+1) clock edges after the edge that sampled start, where V is the number of nodes visited. done is high for exactly one cycle and coincides with the final class.
- R7: start while classifying is ignored: it neither restarts nor extends the walk, and no extra done follows.
- R8: Attribute writes while classifying are ignored: neither the running result nor later results that use the stored attributes change.
- R9: The accumulator is zero at the first step of every node, so a second node's sum does not include the first node's sum.
- R10: result_class changes only in a cycle where done is high, and otherwise holds the last class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| attr_we | input | 1 | Attribute write strobe (load mode only) |
| attr_idx | input | AIDX_W | Attribute slot to write |
| attr_data | input | ATTR_W | Signed attribute value |
| start | input | 1 | Begin classification of the stored instance |
| done | output | 1 | One-cycle pulse when the class is ready |
| result_class | output | CLS_W | Class of the last classified instance |

## Verification
Several properties are checked on every cycle by assertions placed next to their logic. These cover: the done pulse lasting one cycle and always landing in load mode, the step counter staying in range, the walk always entering node 0, the accumulator being zero after each clear, the attribute slots staying frozen while classifying, and result_class holding between pulses. Only the bench scenarios can show the classification results and the exact latency per path length. The same applies to the XOR tree's outcome over positive, negative and saturating sums, and to the point that a spurious start or write during a walk changes nothing that later results depend on.

// File: rtl/dt_pkg.sv
package dt_pkg;

    typedef enum logic {
        MODE_LOAD = 1'b0,
        MODE_EVAL = 1'b1
    } mode_e;

    typedef struct packed {
        logic take_hi;
        logic leaf;
    } verdict_t;

    // Fixed-point scale of coefficients and thresholds: two fractional bits.
    localparam int TREE_FRAC = 2;

    // Coefficient k of a node; k == n_attr is the stored threshold.
    function automatic int tree_coef(int node, int k, int n_attr);
        if (k < n_attr) return 1 << TREE_FRAC;
        if (node == 0)  return 1 << (TREE_FRAC - 1);
        if (node == 1)  return 3 << (TREE_FRAC - 1);
        return 0;
    endfunction

    // Child node address; zero marks a leaf.
    function automatic int tree_child(int node, bit hi);
        if (node == 0 && hi) return 1;
        return 0;
    endfunction

    // Class of a child; meaningful only for leaf children.
    function automatic int tree_class(int node, bit hi);
        if (node == 0) return hi ? 0 : 1;
        if (node == 1) return hi ? 1 : 2;
        return 0;
    endfunction

endpackage

// File: rtl/dt_attr_regs.sv
module dt_attr_regs #(
    parameter int N_ATTR = 2,
    parameter int ATTR_W = 8,
    parameter int AIDX_W = 1,
    parameter int STEP_W = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     frozen,
    input  logic                     we,
    input  logic [AIDX_W-1:0]        widx,
    input  logic signed [ATTR_W-1:0] wdata,
    input  logic [STEP_W-1:0]        ridx,
    output logic signed [ATTR_W-1:0] rdata
);
    logic [N_ATTR-1:0][ATTR_W-1:0] slots;

    always_ff @(posedge clk) begin
        if (rst) begin
            slots <= '0;
        end else if (we && !frozen && (int'(widx) < N_ATTR)) begin
            slots[widx] <= wdata;
        end
    end

    always_comb begin
        if (int'(ridx) < N_ATTR) rdata = $signed(slots[ridx[AIDX_W-1:0]]);
        else                     rdata = '0;
    end

    AST_ATTR_FROZEN: assert property (@(posedge clk) disable iff (rst)
        frozen |=> $stable(slots)); // R8

endmodule

// File: rtl/dt_node_rom.sv
module dt_node_rom
    import dt_pkg::*;
#(
    parameter int N_ATTR  = 2,
    parameter int N_NODES = 2,
    parameter int COEF_W  = 8,
    parameter int NODE_W  = 1,
    parameter int CLS_W   = 2,
    parameter int STEP_W  = 2
) (
    input  logic [NODE_W-1:0]        node,
    input  logic [STEP_W-1:0]        step,
    output logic signed [COEF_W-1:0] coef,
    output logic [NODE_W-1:0]        child_hi,
    output logic [NODE_W-1:0]        child_lo,
    output logic [CLS_W-1:0]         cls_hi,
    output logic [CLS_W-1:0]         cls_lo
);
    localparam int SLICE  = N_ATTR + 1;
    localparam int DEPTH  = N_NODES * SLICE;
    localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic signed [COEF_W-1:0] coef_tab [DEPTH];
    logic [NODE_W-1:0]        chi_tab  [N_NODES];
    logic [NODE_W-1:0]        clo_tab  [N_NODES];
    logic [CLS_W-1:0]         khi_tab  [N_NODES];
    logic [CLS_W-1:0]         klo_tab  [N_NODES];

    for (genvar a = 0; a < DEPTH; a++) begin : g_coef
        assign coef_tab[a] = COEF_W'(tree_coef(a / SLICE, a % SLICE, N_ATTR));
    end

    for (genvar n = 0; n < N_NODES; n++) begin : g_node
        assign chi_tab[n] = NODE_W'(tree_child(n, 1'b1));
        assign clo_tab[n] = NODE_W'(tree_child(n, 1'b0));
        assign khi_tab[n] = CLS_W'(tree_class(n, 1'b1));
        assign klo_tab[n] = CLS_W'(tree_class(n, 1'b0));
    end

    logic [ADDR_W-1:0] addr;
    assign addr = ADDR_W'(int'(node) * SLICE + int'(step));

    always_comb begin
        coef     = '0;
        child_hi = '0;
        child_lo = '0;
        cls_hi   = '0;
        cls_lo   = '0;
        if (int'(addr) < DEPTH) coef = coef_tab[addr];
        if (int'(node) < N_NODES) begin
            child_hi = chi_tab[node];
            child_lo = clo_tab[node];
            cls_hi   = khi_tab[node];
            cls_lo   = klo_tab[node];
        end
    end

endmodule

// File: rtl/dt_mac.sv
module dt_mac #(
    parameter int ATTR_W = 8,
    parameter int COEF_W = 8,
    parameter int ACC_W  = 18
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     clear,
    input  logic                     en,
    input  logic signed [ATTR_W-1:0] attr,
    input  logic signed [COEF_W-1:0] coef,
    output logic                     ge
);
    localparam int PROD_W = ATTR_W + COEF_W;

    logic signed [PROD_W-1:0] prod;
    logic signed [ACC_W-1:0]  acc;
    logic signed [ACC_W-1:0]  thr;

    assign prod = attr * coef;
    assign thr  = ACC_W'(coef);
    assign ge   = (acc >= thr);

    always_ff @(posedge clk) begin
        if (rst || clear) acc <= '0;
        else if (en)      acc <= acc + ACC_W'(prod);
    end

    AST_ACC_CLEARED: assert property (@(posedge clk) disable iff (rst)
        clear |=> (acc == '0)); // R9

endmodule

// File: rtl/dt_ctrl.sv
module dt_ctrl
    import dt_pkg::*;
#(
    parameter int N_ATTR = 2,
    parameter int NODE_W = 1,
    parameter int CLS_W  = 2,
    parameter int STEP_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              ge,
    input  logic [NODE_W-1:0] child_hi,
    input  logic [NODE_W-1:0] child_lo,
    input  logic [CLS_W-1:0]  cls_hi,
    input  logic [CLS_W-1:0]  cls_lo,
    output mode_e             mode,
    output logic [NODE_W-1:0] node,
    output logic [STEP_W-1:0] step,
    output logic              mac_clear,
    output logic              mac_en,
    output logic              done,
    output logic [CLS_W-1:0]  result_class
);
    localparam logic [STEP_W-1:0] LAST = STEP_W'(N_ATTR);

    verdict_t          verdict;
    logic [NODE_W-1:0] next_node;
    logic [CLS_W-1:0]  next_cls;
    logic              deciding;

    assign deciding        = (mode == MODE_EVAL) && (step == LAST);
    assign verdict.take_hi = ge;
    assign next_node       = verdict.take_hi ? child_hi : child_lo;
    assign next_cls        = verdict.take_hi ? cls_hi : cls_lo;
    assign verdict.leaf    = (next_node == '0);

    assign mac_clear = (mode == MODE_LOAD) || deciding;
    assign mac_en    = (mode == MODE_EVAL) && !deciding;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode         <= MODE_LOAD;
            node         <= '0;
            step         <= '0;
            done         <= 1'b0;
            result_class <= '0;
        end else begin
            done <= 1'b0;
            unique case (mode)
                MODE_LOAD: begin
                    if (start) begin
                        mode <= MODE_EVAL;
                        node <= '0;
                        step <= '0;
                    end
                end
                MODE_EVAL: begin
                    if (!deciding) begin
                        step <= step + 1'b1;
                    end else if (verdict.leaf) begin
                        done         <= 1'b1;
                        result_class <= next_cls;
                        mode         <= MODE_LOAD;
                        step         <= '0;
                    end else begin
                        node <= next_node;
                        step <= '0;
                    end
                end
                default: mode <= MODE_LOAD;
            endcase
        end
    end

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R6
    AST_DONE_IN_LOAD: assert property (@(posedge clk) disable iff (rst)
        done |-> (mode == MODE_LOAD)); // R6
    AST_STEP_RANGE: assert property (@(posedge clk) disable iff (rst)
        step <= LAST); // R6
    AST_ROOT_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_LOAD && start) |=> (mode == MODE_EVAL && node == '0 && step == '0)); // R3
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_EVAL && !deciding) |=> (mode == MODE_EVAL)); // R7
    AST_CLASS_HELD: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(result_class)); // R10

endmodule

// File: rtl/dt_seq_classifier.sv
module dt_seq_classifier
    import dt_pkg::*;
#(
    parameter int N_ATTR  = 2,
    parameter int N_NODES = 2,
    parameter int ATTR_W  = 8,
    parameter int COEF_W  = 8,
    parameter int CLS_W   = 2,
    parameter int AIDX_W  = (N_ATTR > 1) ? $clog2(N_ATTR) : 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     attr_we,
    input  logic [AIDX_W-1:0]        attr_idx,
    input  logic signed [ATTR_W-1:0] attr_data,
    input  logic                     start,
    output logic                     done,
    output logic [CLS_W-1:0]         result_class
);
    localparam int NODE_W = (N_NODES > 1) ? $clog2(N_NODES) : 1;
    localparam int STEP_W = $clog2(N_ATTR + 1);
    localparam int ACC_W  = ATTR_W + COEF_W + $clog2(N_ATTR + 1) + 1;

    mode_e                    mode;
    logic [NODE_W-1:0]        node;
    logic [STEP_W-1:0]        step;
    logic                     mac_clear;
    logic                     mac_en;
    logic                     ge;
    logic signed [ATTR_W-1:0] attr_rd;
    logic signed [COEF_W-1:0] coef;
    logic [NODE_W-1:0]        child_hi;
    logic [NODE_W-1:0]        child_lo;
    logic [CLS_W-1:0]         cls_hi;
    logic [CLS_W-1:0]         cls_lo;

    dt_attr_regs #(
        .N_ATTR(N_ATTR), .ATTR_W(ATTR_W), .AIDX_W(AIDX_W), .STEP_W(STEP_W)
    ) u_attr (
        .clk(clk), .rst(rst), .frozen(mode == MODE_EVAL),
        .we(attr_we), .widx(attr_idx), .wdata(attr_data),
        .ridx(step), .rdata(attr_rd)
    );

    dt_node_rom #(
        .N_ATTR(N_ATTR), .N_NODES(N_NODES), .COEF_W(COEF_W),
        .NODE_W(NODE_W), .CLS_W(CLS_W), .STEP_W(STEP_W)
    ) u_rom (
        .node(node), .step(step), .coef(coef),
        .child_hi(child_hi), .child_lo(child_lo),
        .cls_hi(cls_hi), .cls_lo(cls_lo)
    );

    dt_mac #(
        .ATTR_W(ATTR_W), .COEF_W(COEF_W), .ACC_W(ACC_W)
    ) u_mac (
        .clk(clk), .rst(rst), .clear(mac_clear), .en(mac_en),
        .attr(attr_rd), .coef(coef), .ge(ge)
    );

    dt_ctrl #(
        .N_ATTR(N_ATTR), .NODE_W(NODE_W), .CLS_W(CLS_W), .STEP_W(STEP_W)
    ) u_ctrl (
        .clk(clk), .rst(rst), .start(start), .ge(ge),
        .child_hi(child_hi), .child_lo(child_lo),
        .cls_hi(cls_hi), .cls_lo(cls_lo),
        .mode(mode), .node(node), .step(step),
        .mac_clear(mac_clear), .mac_en(mac_en),
        .done(done), .result_class(result_class)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!done && result_class == '0)); // R1

endmodule

// File: tb/dt_seq_classifier_test.sv
module dt_seq_classifier_test;

    localparam int N_ATTR = 2;
    localparam int STEPS  = N_ATTR + 1;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              attr_we = 1'b0;
    logic [0:0]        attr_idx = '0;
    logic signed [7:0] attr_data = '0;
    logic              start = 1'b0;
    logic              done;
    logic [1:0]        result_class;

    dt_seq_classifier uut (
        .clk(clk), .rst(rst), .attr_we(attr_we), .attr_idx(attr_idx),
        .attr_data(attr_data), .start(start), .done(done),
        .result_class(result_class)
    );

    always #5ns clk = ~clk;

    typedef struct {
        int    cls;
        int    lat;
        int    t0;
        string tag;
    } item_t;

    item_t q[$];
    int    cyc = 0;
    int    checks = 0;
    int    fails = 0;
    int    done_count = 0;
    bit    finished = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard on every done pulse.
    bit last_done = 1'b0;
    always @(negedge clk) begin
        if (!rst) begin
            if (last_done) check(done == 1'b0, "R6 done width", int'(done), 0);
            if (done) begin
                if (q.size() == 0) begin
                    check(1'b0, "R7 unexpected done", 1, 0);
                end else begin
                    item_t it;
                    it = q.pop_front();
                    check(int'(result_class) == it.cls, {it.tag, " class"},
                          int'(result_class), it.cls);
                    check(cyc - it.t0 == it.lat, "R6 latency", cyc - it.t0, it.lat);
                end
                done_count++;
            end
            last_done = done;
        end
    end

    function automatic int exp_cls(int s);
        return (s == 1) ? 2 : 1;
    endfunction

    function automatic int exp_visits(int s);
        return (s >= 1) ? 2 : 1;
    endfunction

    task automatic write_attr(input int idx, input int val);
        attr_we   = 1'b1;
        attr_idx  = 1'(idx);
        attr_data = 8'(val);
        @(negedge clk);
        attr_we   = 1'b0;
    endtask

    task automatic launch(input int s, input string tag);
        item_t it;
        it.cls = exp_cls(s);
        it.lat = exp_visits(s) * STEPS;
        it.t0  = cyc + 1;
        it.tag = tag;
        q.push_back(it);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(input int target);
        wait (done_count >= target);
        @(negedge clk);
    endtask

    task automatic classify(input int a0, input int a1, input string tag);
        int target;
        target = done_count + 1;
        write_attr(0, a0);
        write_attr(1, a1);
        launch(a0 + a1, tag);
        wait_done(target);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(done == 1'b0, "R1 done in reset", int'(done), 0);
        check(result_class == 2'd0, "R1 class in reset", int'(result_class), 0);
        rst = 1'b0;
        @(negedge clk);
        check(done == 1'b0, "R1 done after reset", int'(done), 0);
        check(result_class == 2'd0, "R1 class after reset", int'(result_class), 0);

        classify(0, 0, "R2 R3 R4 R5 xor 00");
        classify(0, 1, "R4 R9 xor 01");
        classify(1, 0, "R4 R9 xor 10");
        classify(1, 1, "R4 R5 xor 11");
        classify(-5, 3, "R4 negative sum");
        classify(100, -99, "R4 R9 sum one");
        classify(127, 127, "R4 R9 large sum");
        classify(-128, -128, "R4 most negative");

        // Start and writes during classification are ignored.
        begin
            int target;
            target = done_count + 1;
            write_attr(0, 1);
            write_attr(1, 0);
            launch(1, "R8 stored kept");
            start = 1'b1; attr_we = 1'b1; attr_idx = 1'b0; attr_data = 8'sd1;
            @(negedge clk);
            attr_idx = 1'b1; attr_data = 8'sd1;
            @(negedge clk);
            start = 1'b0; attr_we = 1'b0;
            wait_done(target);
            repeat (10) @(negedge clk);
            check(done_count == target, "R7 no extra done", done_count, target);
            check(result_class == 2'd2, "R10 class held", int'(result_class), 2);
            target = done_count + 1;
            launch(1, "R8 rerun unchanged");
            wait_done(target);
        end

        check(q.size() == 0, "R6 scoreboard drained", q.size(), 0);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL R6 watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule